// File: doc/BRIEF.md
# Per-Stream Programmable Input Offset Receiver

This block is the receive front end of a serial time-division multiplexed link that carries a group of input streams, one bit per clock on each stream. A shared frame pulse marks the start of every frame. Each stream has its own delay setting that says how late, after the frame pulse, the receiver takes bit 0 of the frame. The delay is a whole number of clocks from 0 to 7, plus an optional half clock, so a stream can be shifted by up to 7.5 clock periods. A half-clock shift moves sampling from the rising clock edge to the following falling edge. This lets the receiver line up with streams whose boards and cables add different delays.

The delay settings are written through a 16-bit register port. Each register holds the settings for four streams. Once a stream has locked onto a frame, its bits are gathered into bytes. Each finished byte appears on that stream's output lane for one cycle, together with its channel number within the frame. A mode input picks the framing convention. In ST-BUS mode the frame pulse is active low and each channel arrives most significant bit first. In GCI mode the frame pulse is active high and each channel arrives least significant bit first.

A separate combinational helper turns a frame-alignment measurement into the setting that compensates for it. Software can copy the helper's result straight into the register for that stream.

Top module: `tdm_skew_rx`

## Requirements
- R1: After reset every stream's delay setting is zero, every byte_valid_o bit is low, and the byte data and channel outputs are zero.
- R2: A write with cfg_we_i high stores cfg_wdata_i in register cfg_addr_i. Bits [4j+3:4j] of register a control stream 4a+j. In that nibble, bit 0 is the half-clock enable and bits 3:1 give the whole-clock delay d.
- R3: With the half-clock enable at 0, bit 0 of a frame is the rx_i level at the rising edge that comes d+1 edges after the rising edge at which the frame pulse is seen active. Each later bit of the frame is taken one rising edge later.
- R4: With the half-clock enable at 1, each bit is instead taken at the falling edge half a clock after the rising edge given in R3. The total delay is then d+0.5 clocks, up to 7.5.
- R5: With mode_i = 0 (ST-BUS), the frame pulse is active low and the first bit received in each channel is bit 7 of the byte.
- R6: With mode_i = 1 (GCI), the frame pulse is active high and the first bit received in each channel is bit 0 of the byte.
- R7: After the eighth bit of a channel has been taken, byte_valid_o[s] is high for exactly one cycle. In that cycle byte_data_o[8s+7:8s] holds the byte and byte_chan_o holds its channel number, which counts from 0 starting at frame bit 0.
- R8: The channel number wraps after NUM_CHAN channels. When a stream is delayed, the last bits of a frame that arrive after the next frame pulse are still received without error.
- R9: meas_off_o is the setting that matches measurement meas_i. With meas_i[11] = 1 and meas_i[2:0] = n, the result is delay n with the half-clock enable at 0, written as {n, 0}. With meas_i[11] = 0 it is {n, 1}, meaning n+0.5 clocks. Bits 10:3 are ignored.
- R10: No byte is emitted on any stream until the first frame pulse after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: ST-BUS framing, 1: GCI framing |
| fp_i | input | 1 | Frame pulse; its active level depends on mode_i |
| rx_i | input | NUM_STREAMS | Serial input, one bit per stream |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | CFG_AW | Register index |
| cfg_wdata_i | input | 16 | Register write data |
| meas_i | input | 12 | Frame-alignment measurement |
| meas_off_o | output | 4 | Delay setting derived from meas_i |
| byte_valid_o | output | NUM_STREAMS | One-cycle byte strobe, one bit per stream |
| byte_data_o | output | 8*NUM_STREAMS | Received byte, one lane per stream |
| byte_chan_o | output | CHAN_W*NUM_STREAMS | Channel number of the byte, one lane per stream |

## Verification
The bench sets the eight streams to eight different delays in each run, so a swapped nibble, a wrong bit for the half-clock enable or a register decoded at the wrong address shows up at once as bytes landing on the wrong cycle of some stream. The largest setting, 7.5 clocks, is run across several frames. A design that restarts or drops the tail of a frame when the next pulse arrives would lose the last channel. One that samples on the wrong edge for half-clock streams would take the neighbouring bit. Both framing modes are run with data whose bit patterns differ, so reversed bit order or the wrong frame-pulse level corrupts every byte. A quiet stretch before the first pulse, and measurement values on both sides of the phase bit, cover early output and an inverted conversion.

// File: rtl/tdm_skew_pkg.sv
`timescale 1ns/1ps
package tdm_skew_pkg;
  localparam int unsigned REG_W         = 16;
  localparam int unsigned LANES_PER_REG = 4;
  localparam int unsigned NIB_W         = REG_W / LANES_PER_REG;
  localparam int unsigned MAX_SKEW      = 8;   // 7 whole clocks + 1 half step
  localparam int unsigned MEAS_W        = 12;
  localparam int unsigned MEAS_PHASE    = 11;

  // half is the nibble LSB
  typedef struct packed {
    logic [2:0] whole;
    logic       half;
  } skew_cfg_t;
endpackage

// File: rtl/tdm_skew_cfg.sv
`timescale 1ns/1ps
module tdm_skew_cfg
  import tdm_skew_pkg::*;
#(
  parameter  int unsigned NUM_STREAMS = 8,
  localparam int unsigned NUM_REGS    = (NUM_STREAMS + LANES_PER_REG - 1) / LANES_PER_REG,
  localparam int unsigned AW          = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [REG_W-1:0]            wdata_i,
  output skew_cfg_t [NUM_STREAMS-1:0] cfg_o
);
  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (we_i && (32'(addr_i) < NUM_REGS)) begin
      regs_q[addr_i] <= wdata_i;
    end
  end

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_dec
    assign cfg_o[s] = skew_cfg_t'(regs_q[s / LANES_PER_REG][(s % LANES_PER_REG) * NIB_W +: NIB_W]);
  end
endmodule

// File: rtl/tdm_skew_fp.sv
`timescale 1ns/1ps
module tdm_skew_fp
  import tdm_skew_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic                fp_i,
  output logic [MAX_SKEW:0]   hist_o
);
  logic fp_act;
  // ST-BUS: active low, GCI: active high
  assign fp_act = mode_i ? fp_i : ~fp_i;

  // hist_o[e] is set e+1 rising edges after the pulse was sampled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_o <= '0;
    else         hist_o <= {hist_o[MAX_SKEW-1:0], fp_act};
  end
endmodule

// File: rtl/tdm_skew_lane.sv
`timescale 1ns/1ps
module tdm_skew_lane
  import tdm_skew_pkg::*;
#(
  parameter  int unsigned NUM_CHAN   = 32,
  localparam int unsigned FRAME_BITS = NUM_CHAN * 8,
  localparam int unsigned BW         = $clog2(FRAME_BITS),
  localparam int unsigned CW         = BW - 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  skew_cfg_t         cfg_i,
  input  logic [MAX_SKEW:0] hist_i,
  input  logic              rx_i,
  output logic              valid_o,
  output logic [7:0]        data_o,
  output logic [CW-1:0]     chan_o
);
  logic          rx_fall_q;
  logic [3:0]    skew;
  logic          start, bit_in, live_q;
  logic [BW-1:0] cnt_q, idx;
  logic [7:0]    sh_q, sh_nxt;

  // half-clock path: capture on the falling edge, consume on the next rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_fall_q <= 1'b0;
    else         rx_fall_q <= rx_i;
  end

  assign skew   = {1'b0, cfg_i.whole} + {3'b000, cfg_i.half};
  assign start  = hist_i[skew];
  assign bit_in = cfg_i.half ? rx_fall_q : rx_i;
  assign idx    = start ? '0 : cnt_q;
  assign sh_nxt = mode_i ? {bit_in, sh_q[7:1]} : {sh_q[6:0], bit_in};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      chan_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (start || live_q) begin
        live_q <= 1'b1;
        sh_q   <= sh_nxt;
        cnt_q  <= (idx == BW'(FRAME_BITS - 1)) ? '0 : idx + 1'b1;
        if (idx[2:0] == 3'd7) begin
          valid_o <= 1'b1;
          data_o  <= sh_nxt;
          chan_o  <= idx[BW-1:3];
        end
      end
    end
  end
endmodule

// File: rtl/tdm_skew_meas.sv
`timescale 1ns/1ps
module tdm_skew_meas
  import tdm_skew_pkg::*;
(
  input  logic [MEAS_W-1:0] meas_i,
  output logic [NIB_W-1:0]  off_o
);
  logic unused_mid;
  assign unused_mid = ^meas_i[MEAS_PHASE-1:3];
  // phase bit set: whole clocks only; clear: add the half step
  assign off_o = {meas_i[2:0], ~meas_i[MEAS_PHASE]};
endmodule

// File: rtl/tdm_skew_rx.sv
`timescale 1ns/1ps
module tdm_skew_rx
  import tdm_skew_pkg::*;
#(
  parameter  int unsigned NUM_STREAMS = 8,
  parameter  int unsigned NUM_CHAN    = 32,
  localparam int unsigned CHAN_W      = $clog2(NUM_CHAN),
  localparam int unsigned NUM_REGS    = (NUM_STREAMS + LANES_PER_REG - 1) / LANES_PER_REG,
  localparam int unsigned CFG_AW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          mode_i,
  input  logic                          fp_i,
  input  logic [NUM_STREAMS-1:0]        rx_i,
  input  logic                          cfg_we_i,
  input  logic [CFG_AW-1:0]             cfg_addr_i,
  input  logic [REG_W-1:0]              cfg_wdata_i,
  input  logic [MEAS_W-1:0]             meas_i,
  output logic [NIB_W-1:0]              meas_off_o,
  output logic [NUM_STREAMS-1:0]        byte_valid_o,
  output logic [8*NUM_STREAMS-1:0]      byte_data_o,
  output logic [CHAN_W*NUM_STREAMS-1:0] byte_chan_o
);
  skew_cfg_t [NUM_STREAMS-1:0] lane_cfg;
  logic [MAX_SKEW:0]           fp_hist;

  tdm_skew_cfg #(.NUM_STREAMS(NUM_STREAMS)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (lane_cfg)
  );

  tdm_skew_fp u_fp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_i),
    .fp_i  (fp_i),
    .hist_o(fp_hist)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_lane
    tdm_skew_lane #(.NUM_CHAN(NUM_CHAN)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode_i),
      .cfg_i  (lane_cfg[s]),
      .hist_i (fp_hist),
      .rx_i   (rx_i[s]),
      .valid_o(byte_valid_o[s]),
      .data_o (byte_data_o[8*s +: 8]),
      .chan_o (byte_chan_o[CHAN_W*s +: CHAN_W])
    );
  end

  tdm_skew_meas u_meas (
    .meas_i(meas_i),
    .off_o (meas_off_o)
  );
endmodule

// File: rtl/tdm_skew_chk.sv
`timescale 1ns/1ps
module tdm_skew_chk #(
  parameter int unsigned NUM_STREAMS = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     mode_i,
  input logic                     fp_i,
  input logic [NUM_STREAMS-1:0]   byte_valid_o,
  input logic [4*NUM_STREAMS-1:0] lane_cfg
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      seen_q <= 1'b0;
    else if (mode_i ? fp_i : !fp_i)   seen_q <= 1'b1;
  end

  a_r10_quiet_before_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> byte_valid_o == '0);

  a_r1_cfg_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> lane_cfg == '0);

  a_r1_no_strobe_on_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> byte_valid_o == '0);

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_pulse
    a_r7_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_valid_o[s] |=> !byte_valid_o[s]);
  end
endmodule

bind tdm_skew_rx tdm_skew_chk #(.NUM_STREAMS(NUM_STREAMS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .fp_i        (fp_i),
  .byte_valid_o(byte_valid_o),
  .lane_cfg    (lane_cfg)
);

// File: tb/test_tdm_skew_rx.sv
`timescale 1ns/1ps
module test_tdm_skew_rx;
  localparam int N  = 8;
  localparam int CH = 32;
  localparam int F  = CH * 8;
  localparam int CW = $clog2(CH);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            mode = 1'b0;
  logic            fp = 1'b1;
  logic [N-1:0]    rx = '0;
  logic            cfg_we = 1'b0;
  logic [0:0]      cfg_addr = '0;
  logic [15:0]     cfg_wdata = '0;
  logic [11:0]     meas = '0;
  logic [3:0]      meas_off;
  logic [N-1:0]    bvalid;
  logic [8*N-1:0]  bdata;
  logic [CW*N-1:0] bchan;

  int    pe = 0;
  int    fp_edge = 0;
  bit    running = 1'b0;
  bit    gci = 1'b0;
  bit    done = 1'b0;
  int    skew_e[N];
  bit    half_f[N];
  int    checks = 0;
  int    fails = 0;
  string tag = "R1";

  tdm_skew_rx #(.NUM_STREAMS(N), .NUM_CHAN(CH)) i_tdm_skew_rx (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .fp_i(fp), .rx_i(rx),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .meas_i(meas), .meas_off_o(meas_off),
    .byte_valid_o(bvalid), .byte_data_o(bdata), .byte_chan_o(bchan)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] gen(int s, int c, int fr);
    return 8'((s * 53 + c * 29 + fr * 97 + 17) ^ (c * 8));
  endfunction

  // line level that stream s must present for the rising edge k that consumes it
  function automatic logic bit_at(int s, int k);
    int n, b;
    logic [7:0] byt;
    if (!running) return 1'b0;
    n = k - fp_edge - 1 - skew_e[s];
    if (n < 0) return 1'b0;
    b = n % F;
    byt = gen(s, b / 8, n / F);
    return gci ? byt[b % 8] : byt[7 - (b % 8)];
  endfunction

  function automatic logic fp_level(int k);
    bit act;
    act = running && (k >= fp_edge) && ((k - fp_edge) % F == 0);
    return gci ? act : !act;
  endfunction

  task automatic check_edge(int k);
    for (int s = 0; s < N; s++) begin
      int n;
      bit exp_v;
      n = k - fp_edge - 1 - skew_e[s];
      exp_v = running && (n >= 0) && (n % 8 == 7);
      checks++;
      if (bvalid[s] !== exp_v) begin
        fails++;
        $display("FAIL %s/R7 stream %0d edge %0d valid act=%0b exp=%0b", tag, s, k, bvalid[s], exp_v);
      end else if (exp_v) begin
        logic [7:0] ed;
        int ec;
        ec = (n % F) / 8;
        ed = gen(s, ec, n / F);
        checks++;
        if (bdata[8*s +: 8] !== ed) begin
          fails++;
          $display("FAIL %s/%s stream %0d edge %0d data act=%h exp=%h", tag, gci ? "R6" : "R5",
                   s, k, bdata[8*s +: 8], ed);
        end
        checks++;
        if (bchan[CW*s +: CW] !== CW'(ec)) begin
          fails++;
          $display("FAIL %s/R8 stream %0d edge %0d chan act=%0d exp=%0d", tag, s, k,
                   bchan[CW*s +: CW], ec);
        end
      end
    end
  endtask

  // cycle driver and per-edge reference comparison
  initial begin
    forever begin
      @(posedge clk);
      pe++;
      #1;
      for (int s = 0; s < N; s++) if (half_f[s]) rx[s] = bit_at(s, pe + 1);
      #2.5;
      for (int s = 0; s < N; s++) if (!half_f[s]) rx[s] = bit_at(s, pe + 1);
      fp = fp_level(pe + 1);
      #0.5;
      check_edge(pe);
    end
  end

  task automatic write_cfg(logic [0:0] a, logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    // R2: nibble j of register a -> stream 4a+j, bit0 half enable, bits 3:1 whole delay
    for (int j = 0; j < 4; j++) begin
      logic [3:0] nib;
      nib = d[4*j +: 4];
      skew_e[4*a + j] = int'(nib[3:1]) + int'(nib[0]);
      half_f[4*a + j] = nib[0];
    end
  endtask

  task automatic run_scn(string t, bit g, bit wr, logic [15:0] r0, logic [15:0] r1,
                         int quiet, int frames);
    @(negedge clk);
    running = 1'b0;
    rst_n = 1'b0;
    tag = t;
    gci = g;
    mode = g;
    for (int s = 0; s < N; s++) begin skew_e[s] = 0; half_f[s] = 1'b0; end
    repeat (3) @(negedge clk);
    checks++;  // R1 outputs in reset
    if (bvalid !== '0 || bdata !== '0 || bchan !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs act=%h/%h/%h exp=0/0/0", bvalid, bdata, bchan);
    end
    rst_n = 1'b1;
    @(negedge clk);
    if (wr) begin
      write_cfg(1'b0, r0);
      write_cfg(1'b1, r1);
    end
    repeat (quiet) @(negedge clk);  // R10: no strobe expected here
    fp_edge = pe + 3;
    running = 1'b1;
    while (pe < fp_edge + frames * F + 12) @(negedge clk);
  endtask

  task automatic check_meas(logic [11:0] m);
    logic [3:0] e;
    meas = m;
    #1;
    e = {m[2:0], ~m[11]};
    checks++;
    if (meas_off !== e) begin
      fails++;
      $display("FAIL R9 meas=%h act=%h exp=%h", m, meas_off, e);
    end
  endtask

  initial begin
    for (int s = 0; s < N; s++) begin skew_e[s] = 0; half_f[s] = 1'b0; end
    // R9 conversion on both sides of the phase bit
    check_meas(12'h806);
    check_meas(12'h009);
    check_meas(12'h800);
    check_meas(12'h000);
    check_meas(12'h807);
    check_meas(12'h007);
    check_meas(12'hFF8);
    check_meas(12'h7FB);
    // R1 + R10: default settings, long quiet stretch before the first pulse
    run_scn("R10", 1'b0, 1'b0, 16'h0000, 16'h0000, 300, 3);
    // R2 + R3: ST-BUS, whole delays 0..7 across streams
    run_scn("R3", 1'b0, 1'b1, 16'h6420, 16'hECA8, 20, 3);
    // R4 + R6: GCI, half step on every stream, delays 7.5 down to 0.5
    run_scn("R4", 1'b1, 1'b1, 16'h9BDF, 16'h1357, 20, 3);
    // R8: ST-BUS mixed, including 7.5 and 7.0 spanning the next pulse
    run_scn("R8", 1'b0, 1'b1, 16'hF0E1, 16'h3A5C, 20, 4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule